// File: doc/BRIEF.md
# Banked Interrupt Controller with IRQ/FIQ Steering

This block gathers 128 level-sensitive interrupt sources, organised as four banks of 32, and presents them to a processor core as two request lines: a normal request (IRQ) and a fast request (FIQ). Every bank holds three registers:

- a read-only pending view of its sources;
- an enable register that masks or unmasks each source;
- a steering register that chooses, per source, which request line the source drives.

Software reaches the registers through a small read/write port. The address is made of a bank number and a register kind.

A lookup port runs alongside the request lines. It reports the number of the highest-priority source that is both pending and enabled, together with a valid flag. Software uses it to find which handler to run without scanning the banks itself. The lookup is combinational from the registered pending and enable state, so the answer is ready in the same cycle it is asked for. The source inputs are treated as asynchronous and pass through a two-stage synchroniser before they reach the pending registers.

Top module: `irq_steer_ctrl`

## Requirements
- R1: Source n appears in bank n/32 at bit position n mod 32. Reading address {bank, kind=0} returns that bank's 32 pending bits.
- R2: The pending bits follow the source inputs whatever the enable bits hold. A change on a source input shows in the pending readback after two rising clock edges: it is absent after the first edge and present after the second.
- R3: An enable bit of 1 unmasks the source and 0 masks it. A masked source never raises IRQ or FIQ and is never reported by the lookup.
- R4: A steering bit of 0 routes the source to IRQ and 1 routes it to FIQ. IRQ is the OR of pending AND enable AND NOT steering over all sources. FIQ is the OR of pending AND enable AND steering.
- R5: While reset is held and right after it, every enable and steering bit reads 0, and IRQ, FIQ and the lookup valid flag are 0.
- R6: IRQ and FIQ are registered. They change one clock edge after the pending, enable or steering state that causes the change.
- R7: The lookup is combinational from the registered state. It scans bank 0 first, then banks 1, 2 and 3, and within a bank it picks the lowest set bit of pending AND enable. It returns bank*32 + bit.
- R8: When no enabled source is pending, the lookup valid flag is 0 and the index is 7'h7F, the 7-bit form of -1.
- R9: The register address is {bank[1:0], kind[1:0]}, where kind 0 is pending, 1 is enable and 2 is steering. Kind 3 reads as zero, and writes to kind 3 change no register.
- R10: Writes to the pending kind are ignored. The pending readback, the enable and steering registers, and the outputs are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 128 | Level-sensitive interrupt sources, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | {bank, kind} register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data for reg_addr |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |
| next_valid_o | output | 1 | Lookup found an enabled pending source |
| next_idx_o | output | 7 | Lookup source number, 7'h7F when none |

## Verification
A table of two-source patterns exercises the request lines and the lookup. The patterns place the sources in the same bank and in different banks, at both bank edges (bits 31/32 and 96/127), with one source masked, with both masked, and with either steering. This separates an error in bank order from an error in bit order within a bank, and shows whether a masked source leaks into the lookup or the request lines. Directed cases then cover the following:
- the two-edge synchroniser latency;
- the extra register stage on IRQ, while the lookup already answers;
- readback of pending bits for a masked source;
- that writes to the pending and reserved kinds change nothing.

// File: rtl/irq_steer_pkg.sv
// Shared definitions for the banked interrupt controller.
// Assumes a 2-bit register-kind field in the register address.
package irq_steer_pkg;
    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_PEND  = 2'd0,
        KIND_CTL   = 2'd1,
        KIND_STEER = 2'd2,
        KIND_RSVD  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/irq_sync.sv
// Two-stage synchroniser for a vector of level-sensitive sources.
// Assumes each bit is an independent slow level; there is no bus coherence between bits.
module irq_sync #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two flops in series bring the source levels into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/irq_bank.sv
// One bank of the controller: enable and steering registers, request reduction
// and a lowest-set-bit scan of the enabled pending sources.
// Assumes the write decode for bank and kind is shared across all banks.
module irq_bank
    import irq_steer_pkg::*;
#(
    parameter int BANK_W  = 32,
    parameter int BANK_AW = 2,
    parameter int BANK_ID = 0,
    localparam int BIT_W  = $clog2(BANK_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BANK_AW-1:0] wr_bank,
    input  logic [KIND_W-1:0]  wr_kind,
    input  logic [BANK_W-1:0]  wr_data,
    input  logic [BANK_W-1:0]  pend_i,
    output logic [BANK_W-1:0]  ctl_o,
    output logic [BANK_W-1:0]  steer_o,
    output logic               irq_req_o,
    output logic               fiq_req_o,
    output logic               any_o,
    output logic [BIT_W-1:0]   low_idx_o
);
    logic [BANK_W-1:0] ctl_q;
    logic [BANK_W-1:0] steer_q;
    logic [BANK_W-1:0] active;
    logic              hit;

    assign hit = wr_en && (wr_bank == BANK_AW'(BANK_ID));

    // Enable and steering registers, loaded by a write to this bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            steer_q <= '0;
        end else if (hit) begin
            if (wr_kind == KIND_CTL)   ctl_q   <= wr_data;
            if (wr_kind == KIND_STEER) steer_q <= wr_data;
        end
    end

    assign active = pend_i & ctl_q;

    // Per-bank request lines split by steering.
    always_comb begin
        irq_req_o = |(active & ~steer_q);
        fiq_req_o = |(active & steer_q);
    end

    // Lowest set bit of the enabled pending vector; the last hit in a downward scan wins.
    always_comb begin
        any_o     = |active;
        low_idx_o = '0;
        for (int i = BANK_W - 1; i >= 0; i--) begin
            if (active[i]) low_idx_o = BIT_W'(i);
        end
    end

    assign ctl_o   = ctl_q;
    assign steer_o = steer_q;
endmodule

// File: rtl/irq_bank_sel.sv
// Picks the lowest-numbered bank with an enabled pending source and forms
// the global source index {bank, bit}. All-ones index when nothing is found.
// Assumes the bank size is a power of two, so the index is a plain concatenation.
module irq_bank_sel #(
    parameter int NUM_BANKS = 4,
    parameter int BIT_W     = 5,
    localparam int BANK_AW  = $clog2(NUM_BANKS),
    localparam int IDX_W    = BANK_AW + BIT_W
) (
    input  logic [NUM_BANKS-1:0]       any_i,
    input  logic [NUM_BANKS*BIT_W-1:0] low_idx_i,
    output logic                       valid_o,
    output logic [IDX_W-1:0]           idx_o
);
    // Downward scan so that the lowest-numbered bank with a hit wins.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '1;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (any_i[b]) begin
                valid_o = 1'b1;
                idx_o   = {BANK_AW'(b), low_idx_i[b*BIT_W +: BIT_W]};
            end
        end
    end
endmodule

// File: rtl/irq_steer_ctrl.sv
// Top of the banked interrupt controller. It synchronises the sources, holds the
// per-bank enable and steering registers, drives registered IRQ/FIQ lines and
// provides a combinational next-source lookup.
// Assumes a single clock domain for register access and the request lines.
module irq_steer_ctrl
    import irq_steer_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 32,
    localparam int NUM_SRC  = NUM_BANKS * BANK_W,
    localparam int BANK_AW  = $clog2(NUM_BANKS),
    localparam int BIT_W    = $clog2(BANK_W),
    localparam int IDX_W    = BANK_AW + BIT_W,
    localparam int ADDR_W   = BANK_AW + KIND_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [BANK_W-1:0]  reg_wdata,
    output logic [BANK_W-1:0]  reg_rdata,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               next_valid_o,
    output logic [IDX_W-1:0]   next_idx_o
);
    logic [BANK_AW-1:0]         addr_bank;
    logic [KIND_W-1:0]          addr_kind;
    logic [NUM_SRC-1:0]         pend_all;
    logic [NUM_SRC-1:0]         ctl_all;
    logic [NUM_SRC-1:0]         steer_all;
    logic [NUM_BANKS-1:0]       bank_irq;
    logic [NUM_BANKS-1:0]       bank_fiq;
    logic [NUM_BANKS-1:0]       bank_any;
    logic [NUM_BANKS*BIT_W-1:0] bank_low;
    logic                       irq_q;
    logic                       fiq_q;

    assign addr_bank = reg_addr[ADDR_W-1:KIND_W];
    assign addr_kind = reg_addr[KIND_W-1:0];

    irq_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (pend_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irq_bank #(
            .BANK_W  (BANK_W),
            .BANK_AW (BANK_AW),
            .BANK_ID (b)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_we),
            .wr_bank   (addr_bank),
            .wr_kind   (addr_kind),
            .wr_data   (reg_wdata),
            .pend_i    (pend_all[b*BANK_W +: BANK_W]),
            .ctl_o     (ctl_all[b*BANK_W +: BANK_W]),
            .steer_o   (steer_all[b*BANK_W +: BANK_W]),
            .irq_req_o (bank_irq[b]),
            .fiq_req_o (bank_fiq[b]),
            .any_o     (bank_any[b]),
            .low_idx_o (bank_low[b*BIT_W +: BIT_W])
        );
    end

    irq_bank_sel #(
        .NUM_BANKS (NUM_BANKS),
        .BIT_W     (BIT_W)
    ) u_sel (
        .any_i     (bank_any),
        .low_idx_i (bank_low),
        .valid_o   (next_valid_o),
        .idx_o     (next_idx_o)
    );

    // Registered request lines, ORed across the banks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |bank_irq;
            fiq_q <= |bank_fiq;
        end
    end

    assign irq_o = irq_q;
    assign fiq_o = fiq_q;

    // Readback selected by bank and kind; the reserved kind reads as zero.
    always_comb begin
        unique case (addr_kind)
            KIND_PEND:  reg_rdata = pend_all[addr_bank*BANK_W +: BANK_W];
            KIND_CTL:   reg_rdata = ctl_all[addr_bank*BANK_W +: BANK_W];
            KIND_STEER: reg_rdata = steer_all[addr_bank*BANK_W +: BANK_W];
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_steer_ctrl_chk.sv
// Property checker for irq_steer_ctrl, attached with bind.
// Assumes it sees the flattened pending, enable and steering vectors of the top.
module irq_steer_ctrl_chk #(
    parameter int NUM_SRC = 128,
    parameter int IDX_W   = 7,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_SRC-1:0] pend_all,
    input logic [NUM_SRC-1:0] ctl_all,
    input logic [NUM_SRC-1:0] steer_all,
    input logic               irq_o,
    input logic               fiq_o,
    input logic               next_valid_o,
    input logic [IDX_W-1:0]   next_idx_o
);
    logic [NUM_SRC-1:0] act;
    assign act = pend_all & ctl_all;

    // R4 and R6: IRQ follows the non-steered enabled pending state one edge later.
    p_irq_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_o == $past(|(act & ~steer_all))));

    // R4 and R6: FIQ follows the steered enabled pending state one edge later.
    p_fiq_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fiq_o == $past(|(act & steer_all))));

    // R7: a reported source is enabled and pending.
    p_lookup_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        next_valid_o |-> act[next_idx_o]);

    // R8: no report means no enabled pending source, and the index is all ones.
    p_lookup_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !next_valid_o |-> ((act == '0) && (next_idx_o == '1)));

    // R5: the enable and steering registers are clear on the first cycle after reset.
    p_reset_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ((ctl_all == '0) && (steer_all == '0)));

    // R10: a write to the pending kind leaves enable and steering unchanged.
    p_pend_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[1:0] == 2'd0) |=> ($stable(ctl_all) && $stable(steer_all)));

    // R9: a write to the reserved kind leaves enable and steering unchanged.
    p_rsvd_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[1:0] == 2'd3) |=> ($stable(ctl_all) && $stable(steer_all)));
endmodule

bind irq_steer_ctrl irq_steer_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .pend_all     (pend_all),
    .ctl_all      (ctl_all),
    .steer_all    (steer_all),
    .irq_o        (irq_o),
    .fiq_o        (fiq_o),
    .next_valid_o (next_valid_o),
    .next_idx_o   (next_idx_o)
);

// File: tb/irq_steer_ctrl_bench.sv
// Self-checking bench for irq_steer_ctrl: a vector table, then directed cases.
module irq_steer_ctrl_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src_i = '0;
    logic         reg_we = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq_o;
    logic         fiq_o;
    logic         next_valid_o;
    logic [6:0]   next_idx_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_steer_ctrl u_irq_steer_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src_i),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq_o        (irq_o),
        .fiq_o        (fiq_o),
        .next_valid_o (next_valid_o),
        .next_idx_o   (next_idx_o)
    );

    // One table row: two optional sources (bit 7 marks the source present),
    // their enable and steering bits, and the expected lookup and request lines.
    typedef struct packed {
        logic [7:0] sa;
        logic [7:0] sb;
        logic       ena;
        logic       enb;
        logic       sta;
        logic       stb;
        logic       xv;
        logic [6:0] xi;
        logic       xirq;
        logic       xfiq;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{8'h85, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 7'd5,   1'b1, 1'b0},
        '{8'hA8, 8'h83, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 7'd3,   1'b1, 1'b1},
        '{8'h83, 8'hC6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 7'd70,  1'b0, 1'b1},
        '{8'hFF, 8'hE0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 7'd96,  1'b1, 1'b0},
        '{8'h9F, 8'hA0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 7'd31,  1'b1, 1'b1},
        '{8'hC0, 8'h8A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'h7F,  1'b0, 1'b0},
        '{8'h80, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 7'd0,   1'b0, 1'b1},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'h7F,  1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = addr;
        reg_wdata = data;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic read_reg(input logic [3:0] addr, output logic [31:0] data);
        reg_addr = addr;
        #1;
        data = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] en;
        logic [127:0] st;
        logic [31:0]  rd;

        // R5: reset state while reset is held.
        repeat (3) @(negedge clk);
        check("R5 irq in reset", {31'd0, irq_o}, 32'd0);
        check("R5 fiq in reset", {31'd0, fiq_o}, 32'd0);
        check("R5 valid in reset", {31'd0, next_valid_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int b = 0; b < 4; b++) begin
            read_reg({2'(b), 2'd1}, rd);
            check("R5 control clear", rd, 32'd0);
            read_reg({2'(b), 2'd2}, rd);
            check("R5 steering clear", rd, 32'd0);
        end
        check("R8 none index", {25'd0, next_idx_o}, 32'h7F);

        // Table walk: R3, R4, R7, R8.
        for (int v = 0; v < NV; v++) begin
            src_i = '0;
            en    = '0;
            st    = '0;
            if (TBL[v].sa[7]) begin
                src_i[TBL[v].sa[6:0]] = 1'b1;
                en[TBL[v].sa[6:0]]    = TBL[v].ena;
                st[TBL[v].sa[6:0]]    = TBL[v].sta;
            end
            if (TBL[v].sb[7]) begin
                src_i[TBL[v].sb[6:0]] = 1'b1;
                en[TBL[v].sb[6:0]]    = TBL[v].enb;
                st[TBL[v].sb[6:0]]    = TBL[v].stb;
            end
            for (int b = 0; b < 4; b++) begin
                write_reg({2'(b), 2'd1}, en[b*32 +: 32]);
                write_reg({2'(b), 2'd2}, st[b*32 +: 32]);
            end
            settle();
            check("R7 lookup valid", {31'd0, next_valid_o}, {31'd0, TBL[v].xv});
            check("R7 lookup index", {25'd0, next_idx_o}, {25'd0, TBL[v].xi});
            check("R3 irq line", {31'd0, irq_o}, {31'd0, TBL[v].xirq});
            check("R4 fiq line", {31'd0, fiq_o}, {31'd0, TBL[v].xfiq});
        end

        // Clear everything before the directed cases.
        src_i = '0;
        for (int b = 0; b < 4; b++) begin
            write_reg({2'(b), 2'd1}, 32'd0);
            write_reg({2'(b), 2'd2}, 32'd0);
        end
        settle();

        // R1 and R2: source 40 is masked, shows at bank 1 bit 8 after two edges.
        @(negedge clk);
        src_i[40] = 1'b1;
        @(negedge clk);
        read_reg(4'b0100, rd);
        check("R2 pending after one edge", rd, 32'd0);
        @(negedge clk);
        read_reg(4'b0100, rd);
        check("R1 pending bank1 bit8 masked", rd, 32'h0000_0100);
        check("R3 masked no irq", {31'd0, irq_o}, 32'd0);

        // R10: a write to the pending kind changes nothing.
        write_reg(4'b0100, 32'hFFFF_FFFF);
        read_reg(4'b0100, rd);
        check("R10 pending unchanged", rd, 32'h0000_0100);
        read_reg(4'b0101, rd);
        check("R10 control unchanged", rd, 32'd0);
        check("R10 no irq", {31'd0, irq_o}, 32'd0);

        // R9: the reserved kind reads zero and a write to it changes nothing.
        write_reg(4'b0111, 32'hFFFF_FFFF);
        read_reg(4'b0111, rd);
        check("R9 reserved reads zero", rd, 32'd0);
        read_reg(4'b0101, rd);
        check("R9 control unchanged", rd, 32'd0);
        read_reg(4'b0110, rd);
        check("R9 steering unchanged", rd, 32'd0);

        // R6 and R7: after the enable write, the lookup answers at once and IRQ one edge later.
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 4'b0101;
        reg_wdata = 32'h0000_0100;
        @(negedge clk);
        reg_we = 1'b0;
        check("R7 lookup same cycle", {31'd0, next_valid_o}, 32'd1);
        check("R7 lookup index 40", {25'd0, next_idx_o}, 32'd40);
        check("R6 irq not yet", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        check("R6 irq one edge later", {31'd0, irq_o}, 32'd1);

        // R4: flipping the steering bit moves the request to FIQ.
        write_reg(4'b0110, 32'h0000_0100);
        @(negedge clk);
        check("R4 steered to fiq", {31'd0, fiq_o}, 32'd1);
        check("R4 irq released", {31'd0, irq_o}, 32'd0);

        // R8: the source drops and the lookup reports none.
        src_i = '0;
        settle();
        check("R8 none valid", {31'd0, next_valid_o}, 32'd0);
        check("R8 none index", {25'd0, next_idx_o}, 32'h7F);

        // R5: a second reset clears the registers.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_reg(4'b0101, rd);
        check("R5 control after reset", rd, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule